// File: doc/BRIEF.md
# Serial-to-Parallel Word Receiver with Bit Slip

This block turns a one-bit serial stream into parallel words of `WORD_BITS` bits (2 to 10, default 10). It runs from two clocks taken from one common source: a fast bit clock and a slow word clock at exactly 1/`WORD_BITS` of its rate. On every falling edge of the bit clock, one serial bit enters a shift register.

A bit counter on the same falling edge picks one bit position per word period. On that edge the newly completed word is copied into a holding register. The word clock domain then takes the holding register through a two-stage handover and presents it on `rx_word`.

The load position comes from a static select input. A slip input shifts every later word boundary one bit later, so a receiver that has locked onto the wrong boundary can walk onto the right one. Boundary detection itself is done outside this block.

Top module: `rxd_deser`

## Requirements
- R1: One serial bit is sampled on every falling edge of `bit_clk`. Bits are packed MSB first: the earliest bit of a word appears on `rx_word[WORD_BITS-1]` and the latest on `rx_word[0]`.
- R2: The bit counter is cleared by reset. It then steps 0, 1, …, `WORD_BITS-1`, 0 on successive falling edges; the first falling edge after reset release has count 0. A word is loaded on the falling edge whose count equals the load position. The loaded word consists of the bit taken on that edge and the `WORD_BITS-1` bits before it. With `load_sel` = 2, the load falls on the third falling edge of each word period.
- R3: `load_sel` sets the load position. Values of `WORD_BITS-1` or larger act as `WORD_BITS-1`. `load_sel` is static and is only changed while reset is asserted.
- R4: Each rising edge of `bit_slip`, as seen on a falling edge of `bit_clk`, holds the counter for one edge and suppresses any load on that edge. This delays every later word boundary by exactly one bit. A level held high for several cycles counts as one slip.
- R5: After `WORD_BITS` slips, the word boundaries are back at their original alignment.
- R6: A loaded word appears on `rx_word` at the second rising edge of `word_clk` after the falling edge that loaded it. It stays there until the next word is presented.
- R7: While `rst_n` is low (synchronous, active low, sampled by each clock domain on its own edge), the counter, shift register, holding register and output register clear. `rx_word` reads 0 and `rx_valid` reads 0.
- R8: After reset, `rx_valid` stays 0 and `rx_word` stays 0 until the first word reaches the output register. From then on `rx_valid` stays 1 until the next reset.
- R9: When `WORD_BITS` is below 10, `rx_word[9:WORD_BITS]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast bit clock; bits are taken on its falling edge |
| word_clk | input | 1 | Slow word clock, 1/WORD_BITS of bit_clk, same source |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| ser_in | input | 1 | Serial data bit |
| bit_slip | input | 1 | Rising edge delays all later word boundaries by one bit |
| load_sel | input | 4 | Load position within the word period (static) |
| rx_word | output | 10 | Parallel word, MSB = earliest bit, unused upper bits 0 |
| rx_valid | output | 1 | High once the first word has been presented |

## Verification
A load falls on a bit-clock falling edge. Its word is due on `rx_word` at the second `word_clk` rising edge after that edge. The bench's reference model therefore tags each predicted word with the index of the word-clock edge at which it must appear, and compares the outputs 1 ns after every word-clock rising edge. Slips and held slip levels only move which falling edge loads, so the same due rule applies to them unchanged. A second instance with 8-bit words checks clamping of the load position and the zeroed upper bits under the same timing.

// File: rtl/rxd_pkg.sv
// Package: shared sizes for the serial word receiver.
// Assumes no word is wider than RXD_MAX_BITS; the select port is sized to match.
package rxd_pkg;
    localparam int RXD_MAX_BITS = 10;
    localparam int RXD_SEL_W    = $clog2(RXD_MAX_BITS);
endpackage

// File: rtl/rxd_load_ctrl.sv
// Module: bit counter and load strobe generator (bit_clk falling-edge domain).
// Steps a counter over one word period and strobes load_en when the count
// matches the clamped load position. A rising edge on bit_slip freezes the
// counter for one edge and masks the strobe, delaying later boundaries by a bit.
// Assumes load_sel is static outside reset.
module rxd_load_ctrl
    import rxd_pkg::*;
#(
    parameter int WORD_BITS = 10,
    localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
)(
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 bit_slip,
    input  logic [RXD_SEL_W-1:0] load_sel,
    output logic [CW-1:0]        bit_cnt,
    output logic                 slip_edge,
    output logic                 load_en
);
    localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

    logic          slip_q;
    logic [CW-1:0] pos_eff;

    // Clamp the requested load position into the word period.
    always_comb begin
        if (int'(load_sel) >= WORD_BITS - 1) pos_eff = LAST;
        else                                 pos_eff = CW'(load_sel);
    end

    assign slip_edge = bit_slip & ~slip_q;
    assign load_en   = (bit_cnt == pos_eff) & ~slip_edge;

    // Remember the previous slip level for edge detection.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) slip_q <= 1'b0;
        else        slip_q <= bit_slip;
    end

    // Advance the in-word bit counter, pausing one edge per slip.
    always_ff @(negedge bit_clk) begin
        if (!rst_n)               bit_cnt <= '0;
        else if (slip_edge)       bit_cnt <= bit_cnt;
        else if (bit_cnt == LAST) bit_cnt <= '0;
        else                      bit_cnt <= bit_cnt + CW'(1);
    end
endmodule

// File: rtl/rxd_shift_in.sv
// Module: serial input shift register (bit_clk falling-edge domain).
// Shifts toward the MSB so the oldest bit of a word sits at the top.
// sr_next is the register's value after the current edge and includes the
// bit being taken now. Assumes WORD_BITS >= 2.
module rxd_shift_in #(
    parameter int WORD_BITS = 10
)(
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    output logic [WORD_BITS-1:0] sr_next
);
    logic [WORD_BITS-1:0] sr_q;

    assign sr_next = {sr_q[WORD_BITS-2:0], ser_in};

    // Take one serial bit per falling edge.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_next;
    end
endmodule

// File: rtl/rxd_hold_reg.sv
// Module: parallel holding register (bit_clk falling-edge domain).
// Captures the completed word on load_en and flips a toggle that tells the
// word clock domain a new word is waiting. Assumes loads are at least
// WORD_BITS bit periods apart, so at most one toggle falls in a word period.
module rxd_hold_reg #(
    parameter int WORD_BITS = 10
)(
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [WORD_BITS-1:0] sr_next,
    output logic [WORD_BITS-1:0] hold_word,
    output logic                 hold_tog
);
    // Capture the word and mark it as new.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_tog  <= 1'b0;
        end else if (load_en) begin
            hold_word <= sr_next;
            hold_tog  <= ~hold_tog;
        end
    end
endmodule

// File: rtl/rxd_word_out.sv
// Module: word clock output stage (word_clk rising-edge domain).
// The first edge after a load samples the holding register and its toggle.
// The second edge sees the toggle change and presents the sampled word.
// Assumes word_clk and bit_clk come from one source, so holding data changes
// only on bit_clk falling edges, away from word_clk rising edges.
module rxd_word_out #(
    parameter int WORD_BITS = 10
)(
    input  logic                 word_clk,
    input  logic                 rst_n,
    input  logic [WORD_BITS-1:0] hold_word,
    input  logic                 hold_tog,
    output logic [WORD_BITS-1:0] word_q,
    output logic                 word_valid
);
    logic [WORD_BITS-1:0] stage_word;
    logic                 stage_tog;
    logic                 seen_tog;

    // Sample the holding register once per word period.
    always_ff @(posedge word_clk) begin
        if (!rst_n) begin
            stage_word <= '0;
            stage_tog  <= 1'b0;
            seen_tog   <= 1'b0;
        end else begin
            stage_word <= hold_word;
            stage_tog  <= hold_tog;
            seen_tog   <= stage_tog;
        end
    end

    // Present a sampled word when its toggle is new; valid is sticky.
    always_ff @(posedge word_clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            word_valid <= 1'b0;
        end else if (stage_tog != seen_tog) begin
            word_q     <= stage_word;
            word_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/rxd_deser.sv
// Module: serial-to-parallel word receiver top.
// Joins the falling-edge bit path (shift, count, hold) to the word clock
// output stage and zero-extends the word to the fixed output width.
// Assumes 2 <= WORD_BITS <= RXD_MAX_BITS and a bit_clk exactly WORD_BITS
// times word_clk, both from one source.
module rxd_deser
    import rxd_pkg::*;
#(
    parameter int WORD_BITS = 10,
    localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
)(
    input  logic                    bit_clk,
    input  logic                    word_clk,
    input  logic                    rst_n,
    input  logic                    ser_in,
    input  logic                    bit_slip,
    input  logic [RXD_SEL_W-1:0]    load_sel,
    output logic [RXD_MAX_BITS-1:0] rx_word,
    output logic                    rx_valid
);
    logic [CW-1:0]        bit_cnt;
    logic                 slip_edge;
    logic                 load_en;
    logic [WORD_BITS-1:0] sr_next;
    logic [WORD_BITS-1:0] hold_word;
    logic                 hold_tog;
    logic [WORD_BITS-1:0] word_q;

    rxd_load_ctrl #(.WORD_BITS(WORD_BITS)) u_ctrl (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .bit_slip  (bit_slip),
        .load_sel  (load_sel),
        .bit_cnt   (bit_cnt),
        .slip_edge (slip_edge),
        .load_en   (load_en)
    );

    rxd_shift_in #(.WORD_BITS(WORD_BITS)) u_shift (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .sr_next (sr_next)
    );

    rxd_hold_reg #(.WORD_BITS(WORD_BITS)) u_hold (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .sr_next   (sr_next),
        .hold_word (hold_word),
        .hold_tog  (hold_tog)
    );

    rxd_word_out #(.WORD_BITS(WORD_BITS)) u_out (
        .word_clk   (word_clk),
        .rst_n      (rst_n),
        .hold_word  (hold_word),
        .hold_tog   (hold_tog),
        .word_q     (word_q),
        .word_valid (rx_valid)
    );

    // Widen the word to the port width, tying off unused upper bits.
    generate
        if (WORD_BITS < RXD_MAX_BITS) begin : g_pad
            assign rx_word = {{(RXD_MAX_BITS - WORD_BITS){1'b0}}, word_q};
        end else begin : g_full
            assign rx_word = word_q;
        end
    endgenerate
endmodule

// File: rtl/rxd_deser_chk.sv
// Module: assertion checker for rxd_deser, attached with bind below.
// Watches the counter, load strobe and holding register on bit_clk falling
// edges, and the output pair on word_clk rising edges.
module rxd_deser_chk
    import rxd_pkg::*;
#(
    parameter int WORD_BITS = 10,
    localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
)(
    input logic                    bit_clk,
    input logic                    word_clk,
    input logic                    rst_n,
    input logic [CW-1:0]           bit_cnt,
    input logic                    slip_edge,
    input logic                    load_en,
    input logic [WORD_BITS-1:0]    hold_word,
    input logic [RXD_MAX_BITS-1:0] rx_word,
    input logic                    rx_valid
);
    // R2: the counter never leaves the word period
    p_cnt_range_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        bit_cnt <= CW'(WORD_BITS - 1));

    // R2: no two loads on back-to-back edges
    p_load_spacing_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        load_en |=> !load_en);

    // R2: the holding register changes only on a load
    p_hold_stable_r2: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !load_en |=> $stable(hold_word));

    // R4: a slip freezes the counter for one edge
    p_slip_hold_r4: assert property (@(negedge bit_clk) disable iff (!rst_n)
        slip_edge |=> (bit_cnt == $past(bit_cnt)));

    // R7: reset clears the bit-side state
    p_bit_reset_r7: assert property (@(negedge bit_clk)
        !rst_n |=> (bit_cnt == '0 && hold_word == '0));

    // R7: reset clears the outputs
    p_out_reset_r7: assert property (@(posedge word_clk)
        !rst_n |=> (!rx_valid && rx_word == '0));

    // R8: valid is sticky until reset
    p_valid_sticky_r8: assert property (@(posedge word_clk) disable iff (!rst_n)
        rx_valid |=> rx_valid);

    // R8: no word before valid
    p_idle_zero_r8: assert property (@(posedge word_clk) disable iff (!rst_n)
        !rx_valid |-> (rx_word == '0));

    // R6: the output word moves only once words flow
    p_change_valid_r6: assert property (@(posedge word_clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid);
endmodule

bind rxd_deser rxd_deser_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .bit_clk   (bit_clk),
    .word_clk  (word_clk),
    .rst_n     (rst_n),
    .bit_cnt   (bit_cnt),
    .slip_edge (slip_edge),
    .load_en   (load_en),
    .hold_word (hold_word),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid)
);

// File: tb/rxd_deser_tb.sv
// Bench for rxd_deser: a 10-bit lane (u_dut) and an 8-bit lane (u_dut_b)
// share the bit clock and stimulus. A reference model predicts each word and
// the word clock edge at which it is due.
module rxd_deser_tb;
    localparam int JA = 10;
    localparam int JB = 8;

    logic       bit_clk  = 1'b0;
    logic       clk_a    = 1'b0;
    logic       clk_b    = 1'b0;
    logic       rst_n    = 1'b0;
    logic       ser_in   = 1'b0;
    logic       bit_slip = 1'b0;
    logic [3:0] load_sel = 4'd2;
    logic [9:0] word_a, word_b;
    logic       valid_a, valid_b;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1 R2 R6";

    rxd_deser #(.WORD_BITS(JA)) u_dut (
        .bit_clk(bit_clk), .word_clk(clk_a), .rst_n(rst_n), .ser_in(ser_in),
        .bit_slip(bit_slip), .load_sel(load_sel), .rx_word(word_a), .rx_valid(valid_a));

    rxd_deser #(.WORD_BITS(JB)) u_dut_b (
        .bit_clk(bit_clk), .word_clk(clk_b), .rst_n(rst_n), .ser_in(ser_in),
        .bit_slip(bit_slip), .load_sel(load_sel), .rx_word(word_b), .rx_valid(valid_b));

    // 250 MHz bit clock; word clocks rise together with a bit clock rise
    always #2 bit_clk = ~bit_clk;
    initial begin #2; forever begin clk_a = 1'b1; #(2*JA); clk_a = 1'b0; #(2*JA); end end
    initial begin #2; forever begin clk_b = 1'b1; #(2*JB); clk_b = 1'b0; #(2*JB); end end

    // ---------------- reference model ----------------
    int         m_cnt [2];
    logic [9:0] m_sr  [2];
    logic       m_sq;
    int         scnt  [2];
    logic [9:0] pend_w [2][4];
    bit         pend_v [2][4];
    logic [9:0] e_word [2];
    bit         e_valid[2];

    function automatic int jof(int l);
        return (l == 0) ? JA : JB;
    endfunction

    function automatic int pos_of(int l, logic [3:0] s);
        return (int'(s) >= jof(l) - 1) ? jof(l) - 1 : int'(s);
    endfunction

    initial begin
        for (int l = 0; l < 2; l++) begin
            m_cnt[l] = 0; m_sr[l] = '0; scnt[l] = 0; e_word[l] = '0; e_valid[l] = 0;
            for (int k = 0; k < 4; k++) begin pend_w[l][k] = '0; pend_v[l][k] = 0; end
        end
        m_sq = 1'b0;
    end

    // Bit-side prediction on each falling edge (R1 R2 R3 R4)
    always @(negedge bit_clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 2; l++) begin m_cnt[l] = 0; m_sr[l] = '0; end
            m_sq = 1'b0;
        end else begin
            bit edge_s;
            edge_s = bit_slip && !m_sq;
            for (int l = 0; l < 2; l++) begin
                logic [9:0] nsr;
                nsr = ((m_sr[l] << 1) | 10'(ser_in)) & 10'((1 << jof(l)) - 1);
                if (m_cnt[l] == pos_of(l, load_sel) && !edge_s) begin
                    pend_w[l][(scnt[l] + 2) % 4] = nsr;
                    pend_v[l][(scnt[l] + 2) % 4] = 1;
                end
                m_sr[l] = nsr;
                if (!edge_s) m_cnt[l] = (m_cnt[l] == jof(l) - 1) ? 0 : m_cnt[l] + 1;
            end
            m_sq = bit_slip;
        end
    end

    task automatic check(bit ok, string req, logic [9:0] gw, logic gv,
                         logic [9:0] ew, logic ev);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: word=%h valid=%0b expected word=%h valid=%0b",
                     req, gw, gv, ew, ev);
        end
    endtask

    // Output comparison for one lane, 1 ns after its word clock rises (R6 R7 R8)
    task automatic lane_check(int l, logic r, logic [9:0] gw, logic gv);
        string req;
        if (!r) begin
            e_word[l] = '0; e_valid[l] = 0;
            for (int k = 0; k < 4; k++) pend_v[l][k] = 0;
            req = "R7";
        end else begin
            if (pend_v[l][scnt[l] % 4]) begin
                e_word[l] = pend_w[l][scnt[l] % 4];
                e_valid[l] = 1;
                pend_v[l][scnt[l] % 4] = 0;
            end
            req = e_valid[l] ? cur_req : "R8";
        end
        check(gw == e_word[l] && gv == e_valid[l], req, gw, gv, e_word[l], e_valid[l]);
        if (l == 1) check(gw[9:8] == 2'b00, "R9", gw, gv, {2'b00, gw[7:0]}, gv);
    endtask

    always @(posedge clk_a) begin
        logic r;
        r = rst_n; scnt[0]++;
        #1 lane_check(0, r, word_a, valid_a);
    end

    always @(posedge clk_b) begin
        logic r;
        r = rst_n; scnt[1]++;
        #1 lane_check(1, r, word_b, valid_b);
    end

    // ---------------- stimulus ----------------
    // mode 0: random bits, 1: sparse ones, 2: alternating
    task automatic cycles(int n, int mode, int slip_at, int slip_len);
        for (int i = 0; i < n; i++) begin
            @(posedge bit_clk); #1;
            case (mode)
                0:       ser_in = 1'($urandom);
                1:       ser_in = (i % 7 == 0);
                default: ser_in = i[0];
            endcase
            bit_slip = (i >= slip_at) && (i < slip_at + slip_len);
        end
    endtask

    task automatic do_reset(logic [3:0] sel);
        @(posedge bit_clk); #1;
        rst_n = 1'b0; bit_slip = 1'b0; load_sel = sel;
        cycles(3 * JA + 3, 0, -1, 0);
        @(posedge bit_clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd48611));
        do_reset(4'd2);
        // R7 R8: outputs cleared straight after reset
        check(word_a == '0 && !valid_a, "R7", word_a, valid_a, '0, 1'b0);
        cur_req = "R1 R2 R6";
        cycles(40 * JA, 0, -1, 0);
        cycles(12 * JA, 1, -1, 0);
        cycles(12 * JA, 2, -1, 0);
        // R4: single-cycle and held slip pulses
        cur_req = "R4";
        cycles(6 * JA, 0, 13, 1);
        cycles(6 * JA, 0, 7, 4);
        cycles(6 * JA, 2, 25, 1);
        // R5: a run of slips to wrap the alignment on both lanes
        cur_req = "R5";
        for (int s = 0; s < JA; s++) cycles(3 * JA, 0, s % 5, 2);
        cycles(8 * JA, 1, -1, 0);
        // R3: other load positions, including clamped values
        cur_req = "R3";
        do_reset(4'd0);  cycles(20 * JA, 0, -1, 0);
        do_reset(4'd9);  cycles(20 * JA, 0, -1, 0);
        do_reset(4'd7);  cycles(20 * JA, 2, 30, 1);
        do_reset(4'd15); cycles(20 * JA, 0, -1, 0);
        cur_req = "R1 R2 R6";
        do_reset(4'd2);  cycles(20 * JA, 0, 51, 3);
        cycles(4 * JA, 0, -1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R6: run did not end, expected finish before limit");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule